// File: doc/BRIEF.md
# Pulse-Width Symbol Bit Decoder

This block turns a serial line whose bits are carried by pulse width back into data bits. Every symbol starts on a rising edge and lasts until the next rising edge. A bit of 1 is sent as a short high portion, about 30 % of the symbol. A bit of 0 is sent as a high portion of about half the symbol. The decoder runs from a free-running oversampling clock. It synchronizes and deglitches the line, then counts the samples of the high portion and of the whole symbol. It decides the bit by comparing those two counts.

The threshold is a ratio, not a fixed time. The same decoder therefore follows any symbol rate whose period lies between the minimum and maximum sample counts, with no rate setting. A symbol is complete only when the next rising edge arrives. The decoded bit, or an error strobe for a symbol it cannot classify, appears a fixed number of cycles after that edge.

Top module: `pwd_bit_decoder`

## Requirements
- R1: While rst_ni is low, bit_o, bit_valid_o and err_o are 0, and all measurement state is cleared so that no earlier symbol is remembered.
- R2: The first rising edge after reset only starts a measurement and produces no bit and no error. Every later rising edge closes the symbol that began at the previous rising edge.
- R3: A closed symbol with high time H and period P (both in samples) decodes as bit 0 when 5*H >= 2*P. This covers a 50/50 symbol, and exactly 40 % also decodes as 0.
- R4: A closed symbol decodes as bit 1 when 5*H < 2*P, for example a 30/70 symbol.
- R5: Each decoded bit is reported with bit_valid_o high for exactly one cycle, and bit_o holds its value until the next bit. bit_valid_o and err_o are never high in the same cycle.
- R6: A symbol with a period shorter than MIN_PERIOD samples (default 16) produces a one-cycle err_o pulse and no bit.
- R7: A symbol with a period longer than 2^CNT_W-1 samples (default 1023) produces a one-cycle err_o pulse and no bit. A period of exactly 1023 samples is decoded normally.
- R8: A high or low excursion of the line that lasts a single sample is ignored: it neither creates an edge nor changes the decoded bit.
- R9: After an error symbol, the next symbol is decoded normally, because the rising edge that closed the bad symbol starts the next one.
- R10: The same duty ratio gives the same bit at any period from 16 to 1023 samples, with no configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous pulse-width coded data line |
| bit_o | output | 1 | Last decoded bit |
| bit_valid_o | output | 1 | One-cycle strobe when bit_o takes a new bit |
| err_o | output | 1 | One-cycle strobe for an unclassifiable symbol |

## Verification
The main stream sends 50/50 and 30/70 symbols at periods of 16, 20, 100 and 1023 samples. These show that the decision follows the ratio and not absolute time. High times of 39, 40 and 41 out of 100 fix the exact side of the 40 % threshold. Periods of 15 and 1024 samples lie just outside the limits and must give errors without disturbing the following symbol. A one-sample spike in the low portion of a symbol would create two short false symbols if the filter were bypassed. A reset in mid-stream shows that only the second edge after reset yields a bit.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_ZERO = 2'd1,
    RES_ONE  = 2'd2,
    RES_ERR  = 2'd3
  } res_e;
endpackage

// File: rtl/pwd_sync_filter.sv
module pwd_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;
  logic                   filt_d_q;
  logic                   sync_out;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= line_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN == 1) begin : g_hist1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= sync_out;
    end else begin : g_histn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[FILT_LEN-2:0], sync_out};
    end
  endgenerate

  // level moves only after FILT_LEN agreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q   <= 1'b0;
      filt_d_q <= 1'b0;
    end else begin
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
      filt_d_q <= filt_q;
    end
  end

  assign rise_o = filt_q & ~filt_d_q;
  assign fall_o = ~filt_q & filt_d_q;

  assert_glitch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(sync_out) == filt_q));
endmodule

// File: rtl/pwd_edge_timer.sv
module pwd_edge_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             done_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o,
  output logic             long_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed_q;
  logic             ovf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
      cnt_q   <= '0;
      high_q  <= '0;
    end else begin
      if (rise_i) begin
        armed_q <= 1'b1;
        ovf_q   <= 1'b0;
        cnt_q   <= CNT_W'(1);
      end else if (armed_q) begin
        if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
        else                  cnt_q <= cnt_q + CNT_W'(1);
      end
      if (fall_i && armed_q) high_q <= cnt_q;
    end
  end

  assign done_o   = rise_i & armed_q;
  assign period_o = cnt_q;
  assign high_o   = high_q;
  assign long_o   = ovf_q;

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !rise_i) |=> ovf_q);
endmodule

// File: rtl/pwd_classifier.sv
module pwd_classifier
  import pwd_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int MIN_PERIOD = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             long_i,
  output logic             bit_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam int PW = CNT_W + 3;

  logic [PW-1:0] high_x5;
  logic [PW-1:0] per_x2;
  logic          short_p;
  res_e          res_d;
  res_e          res_q;
  logic          bit_q;

  // 40 % threshold without a divider
  assign high_x5 = {3'b000, high_i} + {1'b0, high_i, 2'b00};
  assign per_x2  = {2'b00, period_i, 1'b0};
  assign short_p = period_i < CNT_W'(MIN_PERIOD);

  always_comb begin
    res_d = RES_NONE;
    if (done_i) begin
      if (long_i || short_p)     res_d = RES_ERR;
      else if (high_x5 < per_x2) res_d = RES_ONE;
      else                       res_d = RES_ZERO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= RES_NONE;
      bit_q <= 1'b0;
    end else begin
      res_q <= res_d;
      if (res_d == RES_ONE)       bit_q <= 1'b1;
      else if (res_d == RES_ZERO) bit_q <= 1'b0;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = (res_q == RES_ONE) || (res_q == RES_ZERO);
  assign err_o   = (res_q == RES_ERR);

  assert_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
endmodule

// File: rtl/pwd_bit_decoder.sv
module pwd_bit_decoder #(
  parameter int CNT_W       = 10,
  parameter int MIN_PERIOD  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic err_o
);
  logic             rise;
  logic             fall;
  logic             done;
  logic             too_long;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] high;

  pwd_sync_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  pwd_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .fall_i  (fall),
    .done_o  (done),
    .period_o(period),
    .high_o  (high),
    .long_o  (too_long)
  );

  pwd_classifier #(
    .CNT_W     (CNT_W),
    .MIN_PERIOD(MIN_PERIOD)
  ) u_cls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .period_i(period),
    .high_i  (high),
    .long_i  (too_long),
    .bit_o   (bit_o),
    .valid_o (bit_valid_o),
    .err_o   (err_o)
  );

  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  assert_err_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

// File: tb/pwd_bit_decoder_bench.sv
`timescale 1ns/1ps
module pwd_bit_decoder_bench;
  localparam int CLK_PERIOD = 62;
  localparam int NV = 13;
  // {high, period, expected: 0 bit0, 1 bit1, 2 error}
  localparam int VEC [0:NV-1][0:2] = '{
    '{8,   16,   0},  // R3 R10
    '{5,   16,   1},  // R4 R10
    '{50,  100,  0},  // R3
    '{30,  100,  1},  // R4
    '{41,  100,  0},  // R3
    '{40,  100,  0},  // R3 threshold
    '{39,  100,  1},  // R4
    '{6,   15,   2},  // R6
    '{10,  20,   0},  // R9
    '{6,   20,   1},  // R4
    '{512, 1023, 0},  // R7 max accepted
    '{500, 1024, 2},  // R7
    '{300, 1023, 1}   // R9 R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_o, bit_valid_o, err_o;

  int total = 0;
  int bad = 0;
  int n_ev = 0;
  logic [1:0] ev_log [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwd_bit_decoder u_pwd_bit_decoder (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .bit_o      (bit_o),
    .bit_valid_o(bit_valid_o),
    .err_o      (err_o)
  );

  always @(negedge clk) begin
    if (rst_n && n_ev < 64) begin
      if (bit_valid_o) begin
        ev_log[n_ev] <= {1'b0, bit_o};
        n_ev <= n_ev + 1;
      end else if (err_o) begin
        ev_log[n_ev] <= 2'd2;
        n_ev <= n_ev + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    line = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic sym(input int h, input int p);
    drive(1'b1, h);
    drive(1'b0, p - h);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 bit_o", bit_o, 0);
    check("R1 bit_valid_o", bit_valid_o, 0);
    check("R1 err_o", err_o, 0);
    rst_n = 1'b1;
    drive(1'b0, 20);

    // table walk: first rise arms only (R2), last closed by a final rise
    base = n_ev;
    for (int i = 0; i < NV; i++) sym(VEC[i][0], VEC[i][1]);
    drive(1'b1, 20);
    drive(1'b0, 4);
    check("R2 event count", n_ev - base, NV);
    for (int i = 0; i < NV; i++)
      check($sformatf("R3/R4/R6/R7 vec%0d", i), int'(ev_log[base + i]), VEC[i][2]);

    // R8 one-sample spike in low portion
    drive(1'b0, 40);
    base = n_ev;
    drive(1'b1, 16); drive(1'b0, 5); drive(1'b1, 1); drive(1'b0, 10);
    sym(16, 32);
    drive(1'b1, 20);
    drive(1'b0, 4);
    check("R8 event count", n_ev - base, 3);
    check("R8 glitch symbol", int'(ev_log[base + 1]), 0);
    check("R8 next symbol", int'(ev_log[base + 2]), 0);

    // R1 R2 reset mid-stream
    drive(1'b1, 10);
    rst_n = 1'b0;
    drive(1'b0, 3);
    check("R1 mid bit_o", bit_o, 0);
    check("R1 mid bit_valid_o", bit_valid_o, 0);
    check("R1 mid err_o", err_o, 0);
    rst_n = 1'b1;
    drive(1'b0, 10);
    base = n_ev;
    sym(16, 32);
    sym(8, 32);
    drive(1'b1, 20);
    drive(1'b0, 4);
    check("R2 after reset count", n_ev - base, 2);
    check("R3 after reset", int'(ev_log[base]), 0);
    check("R4 after reset", int'(ev_log[base + 1]), 1);
    check("R5 bit_o held", bit_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule